// File: doc/BRIEF.md
# Orthogonal-Code Encrypting Serial Transmitter

This block takes a parallel payload word of `DATA_W` bits and expands it into a bi-orthogonal codeword of `CODE_W = 2^(DATA_W-1)` bits. The codewords are widely separated from one another, so a receiver can correct a number of channel errors by picking the nearest codeword. The codeword is then XOR-scrambled with a keystream word of the same width, taken from a maximal-length LFSR. The scrambled word is shifted out one bit per rising clock edge on a single serial line.

The host presents a word on `data_i` and pulses or holds `load_i`. The block accepts the word on a rising edge at which it is idle. It then raises `busy_o` for exactly `CODE_W` cycles while the frame leaves on `sdo_o`, most significant bit first. The LFSR advances once per accepted frame, so a receiver that starts from the same seed and counts frames stays in step with the keystream. The default is `DATA_W = 5`, which gives 16-bit frames.

Top module: `ortho_crypt_tx`

## Requirements
- R1: For payload `d`, let `r = d[DATA_W-2:0]` and `m = r ^ (r[0] << (DATA_W-2))`. Codeword bit `j` (bit 0 is the LSB) equals the parity of `(m & j)`, XOR `d[DATA_W-1]`. With the default width, payload 5'b01001 gives 16'hAAAA.
- R2: All 2^DATA_W codewords are distinct, and any two differ in at least `CODE_W/2` bit positions. Every codeword has exactly `CODE_W/2` ones, except the two for payloads 0 and 2^(DATA_W-1), which are all-zero and all-one.
- R3: The keystream register is reset to seed 1. It shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1 at the default width). The word sent is codeword XOR key. The first frame after reset for payload 01001 is 16'hAAAB.
- R4: The key advances by exactly one step per accepted frame and holds its value on every other cycle.
- R5: On the edge after `load_i` is seen high while idle, `busy_o` goes high and `sdo_o` shows the frame MSB. Each later edge presents the next lower bit. `busy_o` stays high for exactly `CODE_W` cycles.
- R6: `load_i` asserted while `busy_o` is high is ignored: the frame in flight, the data captured and the key sequence are unchanged.
- R7: During reset and whenever idle, `busy_o` and `sdo_o` are low.
- R8: If `load_i` is held high, the next frame is accepted on the first edge at which `busy_o` is low, giving exactly one idle cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Request to send `data_i` |
| data_i | input | DATA_W | Payload word |
| busy_o | output | 1 | High while a frame is being shifted out |
| sdo_o | output | 1 | Serial frame data, MSB first |

## Verification
The bench drives every payload value and deserialises each frame. It removes its own copy of the keystream and compares the result with a parity-built Hadamard table, then checks balance and pairwise distance over the whole recovered set. A wrong row order or a missing inversion bit would show up as a table mismatch. A key that advances per bit instead of per frame, or not at all, would garble every frame after the first. A per-cycle queue model tracks when each frame starts and ends. Loads issued in the middle of a frame check that a design re-accepting while busy would corrupt the stream and skip a key. Holding `load_i` high checks the one-cycle gap between frames, so an off-by-one in the bit counter would stretch or clip a frame.

// File: rtl/ocx_pkg.sv
package ocx_pkg;

    // Feedback tap masks for maximal-length Fibonacci LFSRs, shift-left form:
    // new bit 0 is the XOR of the masked bits.
    function automatic logic [127:0] lfsr_taps(input int width);
        logic [127:0] t;
        t = '0;
        case (width)
            4: begin
                t[3] = 1'b1; t[2] = 1'b1;
            end
            8: begin
                t[7] = 1'b1; t[5] = 1'b1; t[4] = 1'b1; t[3] = 1'b1;
            end
            16: begin
                t[15] = 1'b1; t[13] = 1'b1; t[12] = 1'b1; t[10] = 1'b1;
            end
            32: begin
                t[31] = 1'b1; t[21] = 1'b1; t[1] = 1'b1; t[0] = 1'b1;
            end
            64: begin
                t[63] = 1'b1; t[62] = 1'b1; t[60] = 1'b1; t[59] = 1'b1;
            end
            default: begin
                t[127] = 1'b1; t[125] = 1'b1; t[100] = 1'b1; t[98] = 1'b1;
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ocx_encoder.sv
module ocx_encoder #(
    parameter int DATA_W = 5,
    parameter int CODE_W = 1 << (DATA_W - 1)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int ROW_W = DATA_W - 1;

    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] mask;
    logic             inv;

    assign row  = data_i[ROW_W-1:0];
    assign inv  = data_i[DATA_W-1];
    // swap the row order so that row 9 lands on the alternating pattern
    assign mask = row ^ ({{(ROW_W-1){1'b0}}, row[0]} << (ROW_W - 1));

    for (genvar j = 0; j < CODE_W; j++) begin : g_bit
        assign code_o[j] = (^(mask & ROW_W'(j))) ^ inv;
    end

    always_comb begin
        if (!$isunknown(data_i) && (mask != '0)) begin
            AST_CODE_BALANCED: assert ($countones(code_o) == CODE_W / 2); // R2
        end
    end

endmodule

// File: rtl/ocx_keygen.sv
module ocx_keygen #(
    parameter int          KEY_W = 16,
    parameter logic [127:0] SEED = 128'd1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [KEY_W-1:0] key_o
);
    localparam logic [127:0]     TAPS_ALL = ocx_pkg::lfsr_taps(KEY_W);
    localparam logic [KEY_W-1:0] TAPS     = TAPS_ALL[KEY_W-1:0];
    localparam logic [KEY_W-1:0] SEED_W   = SEED[KEY_W-1:0];

    typedef struct packed {
        logic [KEY_W-1:0] key;
    } kg_state_t;

    kg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.key = {st_q.key[KEY_W-2:0], ^(st_q.key & TAPS)};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.key <= SEED_W;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o = st_q.key;

    AST_KEY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_o != '0); // R3

endmodule

// File: rtl/ocx_serializer.sv
module ocx_serializer #(
    parameter int CODE_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CODE_W-1:0] word_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic              sdo_o
);
    localparam int CNT_W = $clog2(CODE_W);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] shreg;
    } ser_state_t;

    ser_state_t st_d, st_q;

    assign accept_o = load_i && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.shreg = {st_q.shreg[CODE_W-2:0], 1'b0};
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (load_i) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = CNT_W'(CODE_W - 1);
            st_d.shreg = word_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.busy  <= 1'b0;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign sdo_o  = st_q.shreg[CODE_W-1];

    AST_FRAME_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> busy_o && (sdo_o == $past(word_i[CODE_W-1]))); // R5
    AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && st_q.cnt == '0) |=> !busy_o); // R5
    AST_NO_REACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !accept_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !sdo_o); // R7

endmodule

// File: rtl/ortho_crypt_tx.sv
module ortho_crypt_tx #(
    parameter int           DATA_W   = 5,
    parameter logic [127:0] KEY_SEED = 128'd1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              sdo_o
);
    localparam int CODE_W = 1 << (DATA_W - 1);

    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] key;
    logic [CODE_W-1:0] cipher;
    logic              accept;

    ocx_encoder #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_enc (
        .data_i (data_i),
        .code_o (code)
    );

    ocx_keygen #(
        .KEY_W (CODE_W),
        .SEED  (KEY_SEED)
    ) u_key (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (accept),
        .key_o  (key)
    );

    assign cipher = code ^ key;

    ocx_serializer #(
        .CODE_W (CODE_W)
    ) u_ser (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load_i),
        .word_i   (cipher),
        .accept_o (accept),
        .busy_o   (busy_o),
        .sdo_o    (sdo_o)
    );

    AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept |=> $stable(key)); // R4
    AST_KEY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> key != $past(key)); // R4

endmodule

// File: tb/ortho_crypt_tx_tb.sv
module ortho_crypt_tx_tb;
    localparam int DW = 5;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [DW-1:0] data = '0;
    logic          busy;
    logic          sdo;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ortho_crypt_tx #(.DATA_W(DW)) u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .load_i (load),
        .data_i (data),
        .busy_o (busy),
        .sdo_o  (sdo)
    );

    function automatic logic [CW-1:0] ref_code(input int d);
        int r;
        int m;
        logic [CW-1:0] c;
        r = d % CW;
        m = r ^ ((r & 1) << 3);
        for (int j = 0; j < CW; j++) begin
            c[j] = logic'(($countones(m & j) % 2) ^ (d >= CW ? 1 : 0));
        end
        return c;
    endfunction

    function automatic logic [CW-1:0] next_key(input logic [CW-1:0] k);
        return {k[CW-2:0], k[15] ^ k[13] ^ k[12] ^ k[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle reference model
    bit            m_busy = 0;
    bit            m_bits[$];
    logic [CW-1:0] m_key = 16'h0001;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            m_bits.delete();
            m_key  = 16'h0001;
        end else if (m_busy) begin
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) m_busy = 0;
        end else if (load) begin
            logic [CW-1:0] w;
            w = ref_code(int'(data)) ^ m_key;
            for (int i = CW - 1; i >= 0; i--) m_bits.push_back(w[i]);
            m_busy = 1;
            m_key  = next_key(m_key);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R5 busy per cycle", 64'(busy), 64'(m_busy));
            chk(sdo === (m_busy ? m_bits[0] : 1'b0), "R5/R7 sdo per cycle",
                64'(sdo), 64'(m_busy ? m_bits[0] : 1'b0));
        end
    end

    logic [CW-1:0] tb_key = 16'h0001;
    logic [CW-1:0] got[2*CW];

    // entered at a negedge; leaves at the negedge after the frame ends
    task automatic send_frame(input int d, input bit poke, output logic [CW-1:0] w,
                              output logic [CW-1:0] fkey);
        while (busy) @(negedge clk);
        load = 1'b1;
        data = DW'(d);
        @(negedge clk);
        load = 1'b0;
        fkey   = tb_key;
        tb_key = next_key(tb_key);
        w = '0;
        for (int i = 0; i < CW; i++) begin
            w = {w[CW-2:0], sdo};
            if (poke && i >= 5 && i <= 8) begin
                load = 1'b1;
                data = DW'(d ^ 7);
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] w;
        logic [CW-1:0] fk;
        logic [CW-1:0] cw;
        int            gap;

        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && sdo === 1'b0, "R7 reset state", {busy, sdo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && sdo === 1'b0, "R7 idle after reset", {busy, sdo}, 0);

        // R3: first frame after reset
        send_frame(9, 0, w, fk);
        chk(w == 16'hAAAB, "R3 first frame cipher", w, 16'hAAAB);
        chk((w ^ fk) == 16'hAAAA, "R1 payload 01001 codeword", w ^ fk, 16'hAAAA);
        chk(busy === 1'b0 && sdo === 1'b0, "R7 idle after frame", {busy, sdo}, 0);

        // R1, R2, R4: all payloads
        for (int d = 0; d < 2 * CW; d++) begin
            send_frame(d, 0, w, fk);
            cw = w ^ fk;
            got[d] = cw;
            chk(cw == ref_code(d), "R1/R4 decoded codeword", cw, ref_code(d));
            if (d == 0 || d == CW) begin
                chk($countones(cw) == 0 || $countones(cw) == CW, "R2 constant pair",
                    cw, (d == 0) ? 0 : 16'hFFFF);
            end else begin
                chk($countones(cw) == CW / 2, "R2 balance", $countones(cw), CW / 2);
            end
        end
        for (int a = 0; a < 2 * CW; a++) begin
            for (int b = a + 1; b < 2 * CW; b++) begin
                chk($countones(got[a] ^ got[b]) >= CW / 2, "R2 distance",
                    $countones(got[a] ^ got[b]), CW / 2);
            end
        end

        // R6: loads while busy are ignored
        send_frame(3, 1, w, fk);
        chk((w ^ fk) == ref_code(3), "R6 frame unchanged by mid load", w ^ fk, ref_code(3));
        send_frame(12, 0, w, fk);
        chk((w ^ fk) == ref_code(12), "R6/R4 key not skipped", w ^ fk, ref_code(12));

        // R8: load held high
        load = 1'b1;
        data = DW'(21);
        @(negedge clk);
        tb_key = next_key(tb_key);
        while (busy) @(negedge clk);
        gap = 0;
        while (!busy) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == 1, "R8 idle gap with load held", gap, 1);
        load = 1'b0;
        tb_key = next_key(tb_key);
        while (busy) @(negedge clk);

        // R4: idle cycles do not move the key
        repeat (10) @(negedge clk);
        send_frame(30, 0, w, fk);
        chk((w ^ fk) == ref_code(30), "R4 key held while idle", w ^ fk, ref_code(30));

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule